// File: doc/BRIEF.md
# Poly1305 One-Time MAC Engine

The engine produces a 128-bit authentication tag for a byte message under a single-use 256-bit key. The key is divided into a multiplier half `r` and an offset half `s`. The message arrives as a series of 16-byte chunks. Each chunk becomes a padded integer, is added into a running accumulator, and the sum is multiplied by `r` modulo the prime 2^130−5. This evaluates the message polynomial by Horner's rule. After the final chunk, the accumulator is fully reduced, `s` is added modulo 2^128, and the result is presented with a one-cycle strobe.

The caller first pulses `key_load` with the key. It then offers chunks with `chunk_valid` whenever `busy` is low. The last chunk is marked with `chunk_last`, and `chunk_bytes` gives its length in bytes (0 to 16). A length of 0 on the last chunk means that no data chunk follows, so the tag is formed from the accumulator as it stands. For an empty message, that tag is `s`. Each multiply is computed digit by digit over several cycles, and `busy` covers that interval.

Top module: `poly1305_mac`

## Requirements
- R1: The key is taken little-endian: `r` is `key[127:0]` and `s` is `key[255:128]`. `tag` equals (Σ Ci·r^(n−i) mod (2^130−5) + s) mod 2^128, with `tag[7:0]` as the first tag byte.
- R2: On loading, `r` is clamped. The upper four bits of bytes 3, 7, 11 and 15 are cleared, and the lower two bits of bytes 4, 8 and 12 are cleared. Byte k of `r` is `key[8k+7:8k]`.
- R3: Byte k of a chunk sits at `chunk_data[8k+7:8k]`. The chunk value is its used bytes read little-endian, plus a 1 at bit position 8·L. L is 16 for a chunk without `chunk_last`. For a last chunk, L is `chunk_bytes` (values above 16 count as 16). Bytes at positions L and above are ignored.
- R4: Chunks are folded in the order they are accepted: acc ← (acc + C)·r mod (2^130−5).
- R5: Before `s` is added, the accumulator is reduced to a value strictly below 2^130−5. For example, with r = 1 and s = 0, two full chunks of 0xFF bytes give a tag of 3.
- R6: A chunk is accepted when `chunk_valid` is high and both `busy` and `key_load` are low. Acceptance does not occur for a last chunk with `chunk_bytes` = 0. After an accepted chunk, `busy` goes high on the next cycle and stays high for exactly 128/`DIGIT_W` cycles, which is 4 by default.
- R7: While `busy` is high, `chunk_valid` and `key_load` have no effect. When `key_load` and `chunk_valid` are both high in a cycle with `busy` low, the key is loaded and the chunk is dropped.
- R8: Accepting `key_load` clears the accumulator. A last chunk with `chunk_bytes` = 0 gives a tag from the current accumulator without a multiply, so an empty message yields `s`.
- R9: `tag_valid` pulses for one cycle at these points:
  - the first cycle in which `busy` is low after the last chunk's multiply;
  - the cycle after an accepted zero-length last chunk.

  `tag` holds its value between strobes. After reset, `busy`, `tag_valid` and `tag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_load | input | 1 | Load `key` and clear the accumulator (ignored while busy) |
| key | input | 256 | One-time key: `r` in the low half, `s` in the high half |
| chunk_valid | input | 1 | A chunk is offered |
| chunk_data | input | 128 | Chunk bytes, byte 0 in the low bits |
| chunk_bytes | input | 5 | Used byte count of a last chunk (0–16) |
| chunk_last | input | 1 | This chunk ends the message |
| busy | output | 1 | Multiply in progress; chunks and key loads are not taken |
| tag_valid | output | 1 | One-cycle strobe marking a new tag |
| tag | output | 128 | Authentication tag, little-endian |

## Verification
The checker treats the upstream side as well behaved. It assumes that nothing is offered during the two cycles in which the internal reset is still held after `rst_n` rises. It assumes `chunk_bytes` never exceeds 16 on a last chunk. It assumes `key_load` and `chunk_valid` are not raised together in an idle cycle. The stimulus waits for the synchronized reset before its first transfer, uses only lengths of 0 to 16, and presents a key load and a chunk in separate cycles. The stimulus also deliberately holds `chunk_valid` and `key_load` high with junk values during a multiply, and fills the unused bytes of short chunks with junk, to exercise the ignore rules.

// File: rtl/poly1305_pkg.sv
package poly1305_pkg;

  localparam int unsigned HALF_W   = 128;
  localparam int unsigned KEY_W    = 2 * HALF_W;
  localparam int unsigned RED_W    = 130;            // bits of the prime field
  localparam int unsigned ACC_W    = RED_W + 1;      // lazily reduced accumulator
  localparam int unsigned H_W      = RED_W + 2;      // accumulator plus chunk
  localparam int unsigned CHUNK_NB = HALF_W / 8;
  localparam int unsigned NB_W     = $clog2(CHUNK_NB + 1);

  // 2^130 - 5, held one bit wider than the field
  localparam logic [ACC_W-1:0] PRIME = {1'b0, {(RED_W-3){1'b1}}, 3'b011};

  // clear top nibble of every fourth byte, low two bits of bytes 4, 8, 12
  function automatic logic [HALF_W-1:0] clamp_r(input logic [HALF_W-1:0] raw);
    logic [HALF_W-1:0] res;
    res = raw;
    for (int b = 0; b < int'(CHUNK_NB); b++) begin
      if ((b % 4) == 3)
        res[8*b +: 8] = raw[8*b +: 8] & 8'h0f;
      else if ((b % 4) == 0 && b != 0)
        res[8*b +: 8] = raw[8*b +: 8] & 8'hfc;
    end
    return res;
  endfunction

endpackage

// File: rtl/poly1305_chunk_fmt.sv
module poly1305_chunk_fmt
  import poly1305_pkg::*;
(
  input  logic [HALF_W-1:0] data_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic              last_i,
  output logic [HALF_W:0]   val_o
);

  logic [NB_W-1:0] used;

  always_comb begin
    if (!last_i || nbytes_i > NB_W'(CHUNK_NB))
      used = NB_W'(CHUNK_NB);
    else
      used = nbytes_i;
  end

  // byte g passes when below the used length; the byte at the length
  // carries the marker bit in its lowest position
  for (genvar g = 0; g < int'(CHUNK_NB); g++) begin : g_byte
    assign val_o[8*g +: 8] = (NB_W'(g) < used) ? data_i[8*g +: 8]
                                               : {7'b0, used == NB_W'(g)};
  end

  assign val_o[HALF_W] = (used == NB_W'(CHUNK_NB));

endmodule

// File: rtl/poly1305_mulmod.sv
module poly1305_mulmod
  import poly1305_pkg::*;
#(
  parameter int unsigned DIGIT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [H_W-1:0]    h_i,
  input  logic [HALF_W-1:0] r_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ACC_W-1:0]  res_o
);

  localparam int unsigned ND    = (HALF_W + DIGIT_W - 1) / DIGIT_W;
  localparam int unsigned RP_W  = ND * DIGIT_W;
  localparam int unsigned CNT_W = (ND > 1) ? $clog2(ND) : 1;
  localparam int unsigned M_W   = H_W + DIGIT_W;
  localparam int unsigned T_W   = M_W + 1;
  localparam int unsigned HI_W  = T_W - RED_W;

  logic [H_W-1:0]   h_q, h_d;
  logic [ACC_W-1:0] prod_q, prod_d, prod_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  logic [RP_W-1:0]    r_pad;
  logic [DIGIT_W-1:0] digit;
  logic [M_W-1:0]     partial;
  logic [T_W-1:0]     t_sum;
  logic [HI_W-1:0]    t_hi;

  assign r_pad = RP_W'(r_i);
  assign digit = r_pad[int'(cnt_q)*DIGIT_W +: DIGIT_W];

  // one digit step, most significant digit first:
  // prod*2^W + h*digit, then fold bits above 2^130 back in times 5
  always_comb begin
    partial  = {{DIGIT_W{1'b0}}, h_q} * {{H_W{1'b0}}, digit};
    t_sum    = T_W'({prod_q, {DIGIT_W{1'b0}}}) + T_W'(partial);
    t_hi     = t_sum[T_W-1:RED_W];
    prod_nxt = ACC_W'(t_sum[RED_W-1:0]) + (ACC_W'(t_hi) << 2) + ACC_W'(t_hi);
  end

  always_comb begin
    h_d    = h_q;
    prod_d = prod_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    if (run_q) begin
      prod_d = prod_nxt;
      cnt_d  = cnt_q - CNT_W'(1);
      if (cnt_q == '0) run_d = 1'b0;
    end else if (start_i) begin
      h_d    = h_i;
      prod_d = '0;
      cnt_d  = CNT_W'(ND - 1);
      run_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      prod_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      h_q    <= h_d;
      prod_q <= prod_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
    end
  end

  assign busy_o = run_q;
  assign done_o = run_q && (cnt_q == '0);
  assign res_o  = prod_nxt;

endmodule

// File: rtl/poly1305_final.sv
module poly1305_final
  import poly1305_pkg::*;
(
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [HALF_W-1:0] s_i,
  output logic [RED_W-1:0]  red_o,
  output logic [HALF_W-1:0] tag_o
);

  logic [ACC_W-1:0] folded;
  logic [ACC_W-1:0] reduced;

  always_comb begin
    folded  = ACC_W'(acc_i[RED_W-1:0]) + (acc_i[ACC_W-1] ? ACC_W'(5) : '0);
    reduced = (folded >= PRIME) ? (folded - PRIME) : folded;
    red_o   = reduced[RED_W-1:0];
    tag_o   = reduced[HALF_W-1:0] + s_i;
  end

endmodule

// File: rtl/poly1305_mac.sv
module poly1305_mac
  import poly1305_pkg::*;
#(
  parameter int unsigned DIGIT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_load,
  input  logic [KEY_W-1:0]  key,
  input  logic              chunk_valid,
  input  logic [HALF_W-1:0] chunk_data,
  input  logic [NB_W-1:0]   chunk_bytes,
  input  logic              chunk_last,
  output logic              busy,
  output logic              tag_valid,
  output logic [HALF_W-1:0] tag
);

  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  logic [HALF_W-1:0] r_q, r_d, s_q, s_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              last_q, last_d;
  logic [HALF_W-1:0] tag_q, tag_d;
  logic              tag_v_q, tag_v_d;

  logic              key_take, accept, empty_last, mul_start;
  logic              mul_busy, mul_done;
  logic [HALF_W:0]   chunk_val;
  logic [H_W-1:0]    h_sum;
  logic [ACC_W-1:0]  mul_res, fin_in;
  logic [RED_W-1:0]  fin_red;
  logic [HALF_W-1:0] fin_tag;

  poly1305_chunk_fmt u_fmt (
    .data_i   (chunk_data),
    .nbytes_i (chunk_bytes),
    .last_i   (chunk_last),
    .val_o    (chunk_val)
  );

  assign key_take   = key_load && !mul_busy;
  assign accept     = chunk_valid && !mul_busy && !key_load;
  assign empty_last = accept && chunk_last && (chunk_bytes == '0);
  assign mul_start  = accept && !empty_last;
  assign h_sum      = H_W'(acc_q) + H_W'(chunk_val);

  poly1305_mulmod #(.DIGIT_W(DIGIT_W)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .start_i (mul_start),
    .h_i     (h_sum),
    .r_i     (r_q),
    .busy_o  (mul_busy),
    .done_o  (mul_done),
    .res_o   (mul_res)
  );

  assign fin_in = empty_last ? acc_q : mul_res;

  poly1305_final u_fin (
    .acc_i (fin_in),
    .s_i   (s_q),
    .red_o (fin_red),
    .tag_o (fin_tag)
  );

  always_comb begin
    r_d     = r_q;
    s_d     = s_q;
    acc_d   = acc_q;
    last_d  = last_q;
    tag_v_d = (mul_done && last_q) || empty_last;
    tag_d   = tag_v_d ? fin_tag : tag_q;
    if (key_take) begin
      r_d   = clamp_r(key[HALF_W-1:0]);
      s_d   = key[KEY_W-1:HALF_W];
      acc_d = '0;
    end else if (mul_done) begin
      acc_d = mul_res;
    end
    if (mul_start) last_d = chunk_last;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      r_q     <= '0;
      s_q     <= '0;
      acc_q   <= '0;
      last_q  <= 1'b0;
      tag_q   <= '0;
      tag_v_q <= 1'b0;
    end else begin
      r_q     <= r_d;
      s_q     <= s_d;
      acc_q   <= acc_d;
      last_q  <= last_d;
      tag_q   <= tag_d;
      tag_v_q <= tag_v_d;
    end
  end

  assign busy      = mul_busy;
  assign tag_valid = tag_v_q;
  assign tag       = tag_q;

endmodule

// File: rtl/poly1305_mac_chk.sv
module poly1305_mac_chk
  import poly1305_pkg::*;
#(
  parameter int unsigned DIGIT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_load,
  input logic              chunk_valid,
  input logic              chunk_last,
  input logic [NB_W-1:0]   chunk_bytes,
  input logic              busy,
  input logic              tag_valid,
  input logic [HALF_W-1:0] tag,
  input logic [HALF_W-1:0] r_q,
  input logic [ACC_W-1:0]  acc_q,
  input logic [RED_W-1:0]  fin_red
);

  localparam int unsigned ND   = (HALF_W + DIGIT_W - 1) / DIGIT_W;
  localparam int unsigned RUNW = $clog2(ND + 2);
  localparam logic [HALF_W-1:0] CLAMP_OFF = 128'hf0000003f0000003f0000003f0000000;

  logic [RUNW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  busy_run <= '0;
    else if (!busy)              busy_run <= '0;
    else if (busy_run <= RUNW'(ND)) busy_run <= busy_run + RUNW'(1);
  end

  p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (r_q & CLAMP_OFF) == '0);

  p_reduced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, fin_red} < PRIME);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !busy && !key_load && !(chunk_last && chunk_bytes == '0)) |=> busy);

  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < RUNW'(ND)));

  p_key_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_load) |=> $stable(r_q));

  p_key_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && !busy) |=> (acc_q == '0));

  p_tag_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> !busy);

  p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_valid |-> $stable(tag));

endmodule

bind poly1305_mac poly1305_mac_chk #(.DIGIT_W(DIGIT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .key_load    (key_load),
  .chunk_valid (chunk_valid),
  .chunk_last  (chunk_last),
  .chunk_bytes (chunk_bytes),
  .busy        (busy),
  .tag_valid   (tag_valid),
  .tag         (tag),
  .r_q         (r_q),
  .acc_q       (acc_q),
  .fin_red     (fin_red)
);

// File: tb/tb_poly1305_mac.sv
module tb_poly1305_mac;

  localparam int CLK_PERIOD = 10;
  localparam int DIGIT_W    = 32;
  localparam int ND         = 128 / DIGIT_W;

  logic         clk, rst_n;
  logic         key_load;
  logic [255:0] key;
  logic         chunk_valid;
  logic [127:0] chunk_data;
  logic [4:0]   chunk_bytes;
  logic         chunk_last;
  logic         busy, tag_valid;
  logic [127:0] tag;

  poly1305_mac #(.DIGIT_W(DIGIT_W)) dut (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key(key),
    .chunk_valid(chunk_valid), .chunk_data(chunk_data),
    .chunk_bytes(chunk_bytes), .chunk_last(chunk_last),
    .busy(busy), .tag_valid(tag_valid), .tag(tag)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [127:0] exp_q[$];
  logic [127:0] last_tag;
  logic [127:0] last_exp;
  logic [263:0] prime, ref_r, ref_s, ref_acc;
  logic [7:0]   msg [0:127];

  task automatic check(input bit ok, input string req,
                       input logic [263:0] act, input logic [263:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every tag strobe
  always @(negedge clk) begin
    if (rst_n && tag_valid) begin
      last_tag = tag;
      if (exp_q.size() == 0)
        check(1'b0, "R9 unexpected tag strobe", tag, 0);
      else begin
        logic [127:0] e;
        e = exp_q.pop_front();
        check(tag == e, "R1 tag value", tag, e);
      end
    end
  end

  task automatic load_key(input logic [255:0] k);
    key_load = 1'b1;
    key      = k;
    @(negedge clk);
    key_load = 1'b0;
    ref_r    = {136'd0, k[127:0] & 128'h0ffffffc0ffffffc0ffffffc0fffffff};
    ref_s    = {136'd0, k[255:128]};
    ref_acc  = '0;
  endtask

  task automatic send_chunk(input logic [127:0] data, input int nb,
                            input bit last, input bit junk);
    logic [263:0] n;
    int cycles;
    if (!(last && nb == 0)) begin
      n = '0;
      for (int b = 0; b < nb; b++) n[8*b +: 8] = data[8*b +: 8];
      n[8*nb] = 1'b1;
      ref_acc = ((ref_acc + n) * ref_r) % prime;
    end
    if (last) begin
      last_exp = 128'(ref_acc + ref_s);
      exp_q.push_back(last_exp);
    end
    chunk_valid = 1'b1;
    chunk_data  = data;
    chunk_bytes = 5'(nb);
    chunk_last  = last;
    @(negedge clk);
    if (last && nb == 0) begin
      chunk_valid = 1'b0;
      check(tag_valid == 1'b1, "R9 strobe after empty last chunk", tag_valid, 1);
      check(busy == 1'b0, "R8 no multiply for empty last chunk", busy, 0);
      return;
    end
    check(busy == 1'b1, "R6 busy rises after accept", busy, 1);
    if (junk) begin
      chunk_data  = ~data;
      chunk_bytes = 5'd16;
      chunk_last  = 1'b0;
      key_load    = 1'b1;
      key         = {$urandom, $urandom, $urandom, $urandom,
                     $urandom, $urandom, $urandom, $urandom};
    end else begin
      chunk_valid = 1'b0;
    end
    cycles = 0;
    while (busy) begin
      @(negedge clk);
      cycles++;
      chunk_valid = 1'b0;
      key_load    = 1'b0;
      if (cycles > 4 * ND) break;
    end
    check(cycles == ND, "R6 busy length", cycles, ND);
    if (last)
      check(tag_valid == 1'b1, "R9 strobe when busy falls", tag_valid, 1);
  endtask

  task automatic send_msg(input int len, input bit junk);
    if (len == 0) begin
      send_chunk('0, 0, 1'b1, junk);
    end else begin
      for (int off = 0; off < len; off += 16) begin
        logic [127:0] d;
        int nb;
        nb = (len - off < 16) ? (len - off) : 16;
        for (int b = 0; b < 16; b++)
          d[8*b +: 8] = (b < nb) ? msg[off + b] : (8'ha5 ^ 8'(b));
        send_chunk(d, nb, (off + 16 >= len), junk);
      end
    end
    @(negedge clk);
  endtask

  function automatic logic [255:0] rand_key();
    return {$urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic fill_random(input int len);
    for (int i = 0; i < len; i++) msg[i] = 8'($urandom);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog: run hung actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string s;
    logic [255:0] k;
    logic [127:0] fresh;
    int lens[10] = '{1, 15, 16, 17, 31, 32, 33, 47, 64, 80};

    prime       = (264'd1 << 130) - 264'd5;
    rst_n       = 1'b0;
    key_load    = 1'b0;
    key         = '0;
    chunk_valid = 1'b0;
    chunk_data  = '0;
    chunk_bytes = '0;
    chunk_last  = 1'b0;
    last_tag    = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9 reset busy", busy, 0);
    check(tag_valid == 1'b0, "R9 reset tag_valid", tag_valid, 0);
    check(tag == '0, "R9 reset tag", tag, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3: fixed known vector, 34 bytes, short final chunk
    s = "Cryptographic Forum Research Group";
    for (int i = 0; i < s.len(); i++) msg[i] = s[i];
    load_key(256'h1bf54941aff6bf4afdb20dfb8a800301_a806d542fe52447f336d555778bed685);
    send_msg(34, 1'b0);
    check(last_tag == 128'ha927010caf8b2bc2c6365130c11d06a8, "R1 R3 known vector",
          last_tag, 128'ha927010caf8b2bc2c6365130c11d06a8);

    // R5: r=1, s=0, two full 0xFF chunks reduce to 3
    for (int i = 0; i < 32; i++) msg[i] = 8'hff;
    load_key(256'h1);
    send_msg(32, 1'b0);
    check(last_tag == 128'd3, "R5 final subtraction", last_tag, 3);

    // R8: empty message gives s
    k = rand_key();
    load_key(k);
    send_msg(0, 1'b0);
    check(last_tag == k[255:128], "R8 empty message tag", last_tag, k[255:128]);

    // R2: all-ones r must be clamped
    k = {rand_key()[255:128], 128'hffffffffffffffffffffffffffffffff};
    fill_random(16);
    load_key(k);
    send_msg(16, 1'b0);
    check(last_tag == last_exp, "R2 clamped r", last_tag, last_exp);

    // R4 R3: several lengths around chunk boundaries
    foreach (lens[i]) begin
      fill_random(lens[i]);
      load_key(rand_key());
      send_msg(lens[i], 1'b0);
      check(last_tag == last_exp, "R4 multi-chunk order", last_tag, last_exp);
    end

    // R8: reloading the key discards earlier chunks
    k = rand_key();
    fill_random(20);
    load_key(k);
    send_msg(20, 1'b0);
    fresh = last_tag;
    load_key(k);
    send_chunk(128'hdeadbeef_01234567_89abcdef_55aa55aa, 16, 1'b0, 1'b0);
    load_key(k);
    send_msg(20, 1'b0);
    check(last_tag == fresh, "R8 key reload clears accumulator", last_tag, fresh);

    // R7: junk chunk and key offered while busy are ignored
    for (int i = 0; i < 3; i++) begin
      fill_random(40);
      load_key(rand_key());
      send_msg(40, 1'b1);
      check(last_tag == last_exp, "R7 inputs ignored while busy", last_tag, last_exp);
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 every expected tag strobed", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule